// File: doc/BRIEF.md
# PHY Management Register Responder

This block stands in for the management register file of an Ethernet PHY. A host reaches it through a plain register port: a register index, write data, and separate read and write strobes. There are thirty-two 16-bit registers. Most of them simply hold whatever was last written. A few return a value that is worked out at the moment of the read, from the link-up input and the stored advertisement register.

These computed registers make a host see auto-negotiation as already complete. The partner ability always mirrors the speeds the host advertised. The diagnostic register reports the best speed and duplex taken from that advertisement. The status and diagnostic registers read as zero while the link input is low.

Read data is registered. It appears one clock after the read strobe, together with a one-cycle valid pulse, and it holds until the next read.

Top module: `phy_mgmt_regs`

## Requirements
- R1: After reset, register 0 reads 0x3100, register 2 reads 0x0300, register 3 reads 0xE400 and register 4 reads 0x01E1; every other plain register reads 0x0000.
- R2: A write stores the 16-bit data unchanged at the 5-bit index; a later read of a plain register (any index except 1, 5, 17, 18) returns it.
- R3: A read of index 1 returns 0x0000 while link_up_i is low, and 0x782E (bits 14, 13, 12, 11, 5, 3, 2, 1 set) while it is high.
- R4: A read of index 5 returns 0x4000 OR (register 4 AND 0x01E0) OR 0x0001, whatever the link state.
- R5: A read of index 17 always returns 0x8000.
- R6: A read of index 18 returns 0x0000 while link_up_i is low. While it is high, bit 10 is register 4 bit 7 OR bit 8, bit 11 is register 4 bit 8 OR bit 6, and all other bits are zero.
- R7: rd_valid_o is high in exactly the cycle after a cycle with rd_en_i high. rd_data_o changes only then, and holds its value otherwise; both are zero after reset.
- R8: When a write and a read hit the same index in the same cycle, the read returns the value held before the write.
- R9: Writes to indices 1, 5, 17 and 18 are stored but do not change what reads of those indices return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_idx_i | input | 5 | Register index for read and write |
| wr_data_i | input | 16 | Write data |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| link_up_i | input | 1 | Link state used by computed registers |
| rd_data_o | output | 16 | Registered read data |
| rd_valid_o | output | 1 | Pulses one cycle after a read strobe |

## Verification
The assertions assume that reg_idx_i and link_up_i are stable across the clock edge at which rd_en_i is sampled, since the computed values depend on both. They also assume that strobes are only meaningful while rst_ni is high. The stimulus drives every input on the falling edge and holds it for a full cycle. Link changes happen only between transactions, and no strobe is raised during reset.

// File: rtl/phy_mgmt_pkg.sv
`timescale 1ns/1ps
package phy_mgmt_pkg;
  localparam int unsigned IDX_CTRL    = 0;
  localparam int unsigned IDX_STATUS  = 1;
  localparam int unsigned IDX_ID_HI   = 2;
  localparam int unsigned IDX_ID_LO   = 3;
  localparam int unsigned IDX_ADV     = 4;
  localparam int unsigned IDX_PARTNER = 5;
  localparam int unsigned IDX_SPEED   = 17;
  localparam int unsigned IDX_DIAG    = 18;

  localparam logic [15:0] STATUS_UP   = 16'h782E;
  localparam logic [15:0] SPEED_VAL   = 16'h8000;
  localparam logic [15:0] PARTNER_FIX = 16'h4001;
  localparam logic [15:0] ADV_MASK    = 16'h01E0;

  function automatic logic [15:0] reset_val(input int unsigned idx);
    case (idx)
      IDX_CTRL:  return 16'h3100;
      IDX_ID_HI: return 16'h0300;
      IDX_ID_LO: return 16'hE400;
      IDX_ADV:   return 16'h01E1;
      default:   return 16'h0000;
    endcase
  endfunction
endpackage

// File: rtl/phy_mgmt_store.sv
`timescale 1ns/1ps
module phy_mgmt_store
  import phy_mgmt_pkg::*;
#(
  parameter int unsigned IDX_W  = 5,
  parameter int unsigned DATA_W = 16,
  localparam int unsigned NREG  = 1 << IDX_W
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           wr_en_i,
  input  logic [IDX_W-1:0]               wr_idx_i,
  input  logic [DATA_W-1:0]              wr_data_i,
  output logic [NREG-1:0][DATA_W-1:0]    regs_o
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [DATA_W-1:0] RST = DATA_W'(reset_val(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        regs_o[g] <= RST;
      else if (wr_en_i && wr_idx_i == IDX_W'(g))
        regs_o[g] <= wr_data_i;
    end
  end
endmodule

// File: rtl/phy_mgmt_view.sv
`timescale 1ns/1ps
module phy_mgmt_view
  import phy_mgmt_pkg::*;
#(
  parameter int unsigned IDX_W  = 5,
  parameter int unsigned DATA_W = 16,
  localparam int unsigned NREG  = 1 << IDX_W
) (
  input  logic [IDX_W-1:0]            idx_i,
  input  logic                        link_up_i,
  input  logic [NREG-1:0][DATA_W-1:0] regs_i,
  output logic [DATA_W-1:0]           val_o
);
  logic [DATA_W-1:0] adv;
  logic              fast, full;

  assign adv  = regs_i[IDX_ADV];
  // best advertised speed and duplex
  assign fast = adv[7] | adv[8];
  assign full = adv[8] | adv[6];

  always_comb begin
    val_o = regs_i[idx_i];
    unique case (idx_i)
      IDX_W'(IDX_STATUS):  val_o = link_up_i ? DATA_W'(STATUS_UP) : '0;
      IDX_W'(IDX_PARTNER): val_o = DATA_W'(PARTNER_FIX) | (adv & DATA_W'(ADV_MASK));
      IDX_W'(IDX_SPEED):   val_o = DATA_W'(SPEED_VAL);
      IDX_W'(IDX_DIAG): begin
        val_o = '0;
        if (link_up_i) begin
          val_o[10] = fast;
          val_o[11] = full;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/phy_mgmt_regs.sv
`timescale 1ns/1ps
module phy_mgmt_regs #(
  parameter int unsigned IDX_W  = 5,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  reg_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic              link_up_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o
);
  localparam int unsigned NREG = 1 << IDX_W;

  logic [NREG-1:0][DATA_W-1:0] regs;
  logic [DATA_W-1:0]           view_val;

  phy_mgmt_store #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_idx_i  (reg_idx_i),
    .wr_data_i (wr_data_i),
    .regs_o    (regs)
  );

  phy_mgmt_view #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_view (
    .idx_i     (reg_idx_i),
    .link_up_i (link_up_i),
    .regs_i    (regs),
    .val_o     (view_val)
  );

  // view reads pre-write contents: same-cycle write is not forwarded
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_data_o  <= '0;
      rd_valid_o <= 1'b0;
    end else begin
      rd_valid_o <= rd_en_i;
      if (rd_en_i) rd_data_o <= view_val;
    end
  end
endmodule

// File: rtl/phy_mgmt_regs_chk.sv
`timescale 1ns/1ps
module phy_mgmt_regs_chk #(
  parameter int unsigned IDX_W  = 5,
  parameter int unsigned DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [IDX_W-1:0]  reg_idx_i,
  input logic              rd_en_i,
  input logic              link_up_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              rd_valid_o
);
  // R7
  valid_follows_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> rd_valid_o);
  // R7
  no_spurious_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> !rd_valid_o);
  // R7
  data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rd_data_o));
  // R3
  status_down_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && reg_idx_i == IDX_W'(1) && !link_up_i) |=> rd_data_o == '0);
  // R4
  partner_fixed_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && reg_idx_i == IDX_W'(5)) |=> (rd_data_o[0] && rd_data_o[14] && !rd_data_o[15]));
  // R5
  speed_const_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && reg_idx_i == IDX_W'(17)) |=> rd_data_o == DATA_W'(16'h8000));
  // R6
  diag_down_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && reg_idx_i == IDX_W'(18) && !link_up_i) |=> rd_data_o == '0);
endmodule

bind phy_mgmt_regs phy_mgmt_regs_chk #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_idx_i  (reg_idx_i),
  .rd_en_i    (rd_en_i),
  .link_up_i  (link_up_i),
  .rd_data_o  (rd_data_o),
  .rd_valid_o (rd_valid_o)
);

// File: tb/phy_mgmt_regs_test.sv
`timescale 1ns/1ps
module phy_mgmt_regs_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [4:0]  reg_idx_i = '0;
  logic [15:0] wr_data_i = '0;
  logic        wr_en_i = 1'b0;
  logic        rd_en_i = 1'b0;
  logic        link_up_i = 1'b1;
  logic [15:0] rd_data_o;
  logic        rd_valid_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  int unsigned mreg [32];
  logic [15:0] exp_data = '0;
  logic        exp_valid = 1'b0;

  always #5 clk_i = ~clk_i;

  phy_mgmt_regs uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .reg_idx_i(reg_idx_i), .wr_data_i(wr_data_i),
    .wr_en_i(wr_en_i), .rd_en_i(rd_en_i), .link_up_i(link_up_i),
    .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o)
  );

  function automatic logic [15:0] model_read(input int idx, input logic lnk);
    int unsigned a = mreg[4];
    int unsigned v;
    case (idx)
      1:  v = lnk ? 'h782E : 0;
      5:  v = 'h4000 + (a & 'h01E0) + 1;
      17: v = 'h8000;
      18: begin
        v = 0;
        if (lnk) begin
          if (((a >> 7) & 1) != 0 || ((a >> 8) & 1) != 0) v += 'h0400;
          if (((a >> 8) & 1) != 0 || ((a >> 6) & 1) != 0) v += 'h0800;
        end
      end
      default: v = mreg[idx];
    endcase
    return v[15:0];
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one clock: drive at negedge, model at posedge, compare at next negedge
  task automatic cyc(input int idx, input int unsigned d, input logic we, input logic re,
                     input logic lnk, input string tag);
    reg_idx_i = idx[4:0];
    wr_data_i = d[15:0];
    wr_en_i   = we;
    rd_en_i   = re;
    link_up_i = lnk;
    @(posedge clk_i);
    exp_valid = re;
    if (re) exp_data = model_read(idx, lnk);
    if (we) mreg[idx] = d & 'hFFFF;
    @(negedge clk_i);
    check({tag, " valid"}, {15'd0, rd_valid_o}, {15'd0, exp_valid});
    check({tag, " data"}, rd_data_o, exp_data);
    wr_en_i = 1'b0;
    rd_en_i = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) mreg[i] = 0;
    mreg[0] = 'h3100; mreg[2] = 'h0300; mreg[3] = 'hE400; mreg[4] = 'h01E1;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R7 reset valid", {15'd0, rd_valid_o}, 16'd0);
    check("R7 reset data", rd_data_o, 16'd0);

    // R1 reset contents
    cyc(0, 0, 0, 1, 1, "R1 reg0");
    cyc(2, 0, 0, 1, 1, "R1 reg2");
    cyc(3, 0, 0, 1, 1, "R1 reg3");
    cyc(4, 0, 0, 1, 1, "R1 reg4");
    cyc(6, 0, 0, 1, 1, "R1 reg6");
    cyc(31, 0, 0, 1, 1, "R1 reg31");

    // R2 write and read back
    cyc(9, 'hA5A5, 1, 0, 1, "R2 write");
    cyc(9, 0, 0, 1, 1, "R2 read");
    // R8 same-cycle write/read sees old value
    cyc(9, 'h1234, 1, 1, 1, "R8 collide");
    cyc(9, 0, 0, 1, 1, "R8 after");

    // R7 hold while idle
    cyc(0, 0, 0, 0, 1, "R7 idle1");
    cyc(3, 'h7777, 0, 0, 0, "R7 idle2");

    // R3 status
    cyc(1, 0, 0, 1, 1, "R3 up");
    cyc(1, 0, 0, 1, 0, "R3 down");

    // R4 / R6 against several advertisement values
    cyc(5, 0, 0, 1, 1, "R4 default");
    cyc(18, 0, 0, 1, 1, "R6 default");
    cyc(4, 'h0040, 1, 0, 1, "R6 adv10f");
    cyc(5, 0, 0, 1, 1, "R4 adv10f");
    cyc(18, 0, 0, 1, 1, "R6 adv10f");
    cyc(4, 'h0080, 1, 0, 1, "R6 adv100h");
    cyc(18, 0, 0, 1, 1, "R6 adv100h");
    cyc(4, 'h0100, 1, 0, 1, "R6 adv100f");
    cyc(18, 0, 0, 1, 1, "R6 adv100f");
    cyc(18, 0, 0, 1, 0, "R6 down");
    cyc(4, 'hFE3F, 1, 0, 1, "R4 adv mask");
    cyc(5, 0, 0, 1, 0, "R4 down");
    cyc(18, 0, 0, 1, 1, "R6 none");

    // R5
    cyc(17, 0, 0, 1, 1, "R5 up");
    cyc(17, 0, 0, 1, 0, "R5 down");

    // R9 writes to computed indices ignored on read
    cyc(17, 'h0000, 1, 0, 1, "R9 w17");
    cyc(17, 0, 0, 1, 1, "R9 r17");
    cyc(1, 'hFFFF, 1, 0, 0, "R9 w1");
    cyc(1, 0, 0, 1, 0, "R9 r1");
    cyc(5, 'h0000, 1, 0, 1, "R9 w5");
    cyc(5, 0, 0, 1, 1, "R9 r5");
    cyc(18, 'hFFFF, 1, 0, 1, "R9 w18");
    cyc(18, 0, 0, 1, 0, "R9 r18");

    // R2 sweep over all indices
    for (int i = 0; i < 32; i++) cyc(i, (i * 'h0841) ^ 'h5A3C, 1, 0, 1, "R2 sweep w");
    for (int i = 0; i < 32; i++) cyc(i, 0, 0, 1, 1, "R2 sweep r");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule